// File: doc/BRIEF.md
# Multi-Format Serial PCM Receiver

This block is the receive side of a stereo serial audio port that always runs as a clock slave. It takes three inputs from an external source: a bit clock, a word (left/right) clock and a serial data line. It never drives any of them. All three are synchronous with the faster master clock of the block, so they are sampled in that domain. Rising edges of the bit clock are found there, and data and word select are taken at each one.

Two framings are decoded by one datapath. In left-justified framing the MSB arrives at the first bit-clock rise after the word clock changes. In I2S framing it arrives one slot later. I2S framing is handled as left-justified framing with a one-slot-delayed word select. Samples are 16 or 18 bits, MSB first, and bit-clock ratios of 32, 48 or 64 per sample period are accepted. Each completed stereo pair appears on two 18-bit buses with a one-cycle valid strobe. The configuration inputs are static and are changed only while reset is held.

Top module: `pcm_serial_rx`

## Requirements
- R1: While reset is applied and after it is released, `valid_o` is low and `left_o`/`right_o` are zero until the first pair is delivered.
- R2: With `cfg_lj`=1 (left-justified), word clock high is the left channel, and the MSB is the bit taken at the first bit-clock rise after a word-clock change.
- R3: With `cfg_lj`=0 (I2S), word clock low is the left channel, and the MSB is the bit taken at the second bit-clock rise after a word-clock change.
- R4: With `cfg_p18`=0, 16 bits are captured per channel and placed in bits 17..2 of the output, with bits 1..0 zero.
- R5: With `cfg_p18`=1 and a ratio of 48 or 64, 18 bits are captured per channel and fill bits 17..0.
- R6: `cfg_ratio` gives 16, 24 or 32 slots per channel for the codes 0, 1 and 2 (code 3 acts as 2). With code 0 and 18-bit precision, only 16 bits are captured and bits 1..0 are zero.
- R7: Data slots after the last captured bit of a channel are ignored. Driving them high does not change the output.
- R8: `valid_o` is a single-cycle pulse, once per stereo pair. It rises after the right channel is complete, when the next left half begins. The outputs change only with that pulse.
- R9: A word-clock change that arrives early restarts the bit position. The shortened channel keeps only the bits received, with zero LSBs, and the next frame decodes correctly.
- R10: No pair is delivered until a left half and then a right half have each been entered through a word-clock change after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; bit and word clocks are synchronous to it |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lj | input | 1 | Framing: 1 left-justified, 0 I2S |
| cfg_p18 | input | 1 | Precision: 1 for 18 bits, 0 for 16 bits |
| cfg_ratio | input | 2 | Bit-clock ratio: 0 for 32x, 1 for 48x, 2 or 3 for 64x |
| bit_clk_i | input | 1 | External serial bit clock |
| word_clk_i | input | 1 | External left/right word clock |
| ser_data_i | input | 1 | Serial PCM data, MSB first |
| left_o | output | 18 | Left sample, left-aligned |
| right_o | output | 18 | Right sample, left-aligned |
| valid_o | output | 1 | One-cycle strobe marking a new stereo pair |

## Verification
A bit position counter that is off by one shows up at the ports as a word shifted by one place, with the MSB lost or a trailing junk bit pulled in. This appears in the very first delivered pair. A wrong channel decode or a wrong framing delay swaps the channels or adds a one-slot skew, which the scoreboard sees in the first pair. A capture limit that is too generous lets the high junk bits into the LSBs. A broken word-edge detector either stops the valid pulses or delivers pairs early, so the scoreboard finds a missing or unexpected item within one frame.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

  localparam int SAMPLE_W = 18;
  localparam int CNT_W    = 6;

  typedef enum logic [1:0] {
    RATIO_32X = 2'd0,
    RATIO_48X = 2'd1,
    RATIO_64X = 2'd2
  } ratio_e;

  // bit slots in one channel half for a ratio code
  function automatic logic [CNT_W-1:0] slots_per_half(input logic [1:0] code);
    case (code)
      RATIO_32X: return CNT_W'(16);
      RATIO_48X: return CNT_W'(24);
      default:   return CNT_W'(32);
    endcase
  endfunction

  // number of data bits taken per channel: precision limited by slot count
  function automatic logic [CNT_W-1:0] capture_bits(input logic p18, input logic [1:0] code);
    logic [CNT_W-1:0] prec;
    logic [CNT_W-1:0] slots;
    prec  = p18 ? CNT_W'(18) : CNT_W'(16);
    slots = slots_per_half(code);
    return (prec < slots) ? prec : slots;
  endfunction

endpackage

// File: rtl/pcm_in_sync.sv
module pcm_in_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] q_prev_o
);

  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev_q;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[gi] <= '0;
        else if (gi == 0) stg[gi] <= d_i;
        else stg[gi] <= stg[(gi == 0) ? 0 : gi-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stg[STAGES-1];
  end

  assign q_o      = stg[STAGES-1];
  assign q_prev_o = prev_q;

endmodule

// File: rtl/pcm_deser.sv
module pcm_deser
  import pcm_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_rise_i,
  input  logic                ws_i,
  input  logic                sd_i,
  input  logic                cfg_lj,
  input  logic [CNT_W-1:0]    cap_lim_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o,
  output logic                frame_edge_o,
  output logic [CNT_W-1:0]    bit_cnt_o
);

  logic                ws_last_q, eff_last_q;
  logic                l_started_q, r_started_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [SAMPLE_W-1:0] acc_l_q, acc_r_q, left_q, right_q;
  logic                valid_q;

  logic                eff_ws, in_left, edge_w, hit;
  logic [CNT_W-1:0]    idx, sh;
  logic [SAMPLE_W-1:0] mask, dmask;

  always_comb begin
    // I2S is left-justified framing with word select delayed one slot
    eff_ws  = cfg_lj ? ws_i : ws_last_q;
    in_left = cfg_lj ? eff_ws : ~eff_ws;
    edge_w  = bit_rise_i && (eff_ws != eff_last_q);
    idx     = edge_w ? '0 : ((&cnt_q) ? cnt_q : cnt_q + 1'b1);
    hit     = idx < cap_lim_i;
    sh      = CNT_W'(SAMPLE_W-1) - idx;
    mask    = hit ? (SAMPLE_W'(1) << sh) : '0;
    dmask   = sd_i ? mask : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_last_q   <= 1'b0;
      eff_last_q  <= 1'b0;
      cnt_q       <= '1;
      acc_l_q     <= '0;
      acc_r_q     <= '0;
      left_q      <= '0;
      right_q     <= '0;
      valid_q     <= 1'b0;
      l_started_q <= 1'b0;
      r_started_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (bit_rise_i) begin
        ws_last_q  <= ws_i;
        eff_last_q <= eff_ws;
        cnt_q      <= idx;
        if (in_left) acc_l_q <= edge_w ? dmask : ((acc_l_q & ~mask) | dmask);
        else         acc_r_q <= edge_w ? dmask : ((acc_r_q & ~mask) | dmask);
        if (edge_w && in_left) begin
          l_started_q <= 1'b1;
          if (r_started_q) begin
            valid_q <= 1'b1;
            left_q  <= acc_l_q;
            right_q <= acc_r_q;
          end
        end
        if (edge_w && !in_left && l_started_q) r_started_q <= 1'b1;
      end
    end
  end

  assign left_o       = left_q;
  assign right_o      = right_q;
  assign valid_o      = valid_q;
  assign frame_edge_o = edge_w;
  assign bit_cnt_o    = cnt_q;

endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
  import pcm_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_lj,
  input  logic                cfg_p18,
  input  logic [1:0]          cfg_ratio,
  input  logic                bit_clk_i,
  input  logic                word_clk_i,
  input  logic                ser_data_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);

  localparam int N_IN = 3;

  logic [N_IN-1:0]  raw_w, sync_w, prev_w;
  logic             bclk_rise_w;
  logic             frame_edge_w;
  logic [CNT_W-1:0] bit_cnt_w;
  logic [CNT_W-1:0] bit_lim_w;

  assign raw_w = {ser_data_i, word_clk_i, bit_clk_i};

  pcm_in_sync #(.W(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .d_i      (raw_w),
    .q_o      (sync_w),
    .q_prev_o (prev_w)
  );

  assign bclk_rise_w = sync_w[0] & ~prev_w[0];
  assign bit_lim_w   = capture_bits(cfg_p18, cfg_ratio);

  pcm_deser u_deser (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_rise_i   (bclk_rise_w),
    .ws_i         (sync_w[1]),
    .sd_i         (sync_w[2]),
    .cfg_lj       (cfg_lj),
    .cap_lim_i    (bit_lim_w),
    .left_o       (left_o),
    .right_o      (right_o),
    .valid_o      (valid_o),
    .frame_edge_o (frame_edge_w),
    .bit_cnt_o    (bit_cnt_w)
  );

endmodule

// File: rtl/pcm_rx_chk.sv
module pcm_rx_chk
  import pcm_rx_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                valid_o,
  input logic [SAMPLE_W-1:0] left_o,
  input logic [SAMPLE_W-1:0] right_o,
  input logic                cfg_p18,
  input logic [1:0]          cfg_ratio,
  input logic                frame_edge,
  input logic [CNT_W-1:0]    bit_cnt
);

  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  p_valid_after_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(frame_edge));

  p_hold_left_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(left_o) |-> valid_o);

  p_hold_right_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(right_o) |-> valid_o);

  p_lsb_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !cfg_p18) |-> (left_o[1:0] == 2'b00 && right_o[1:0] == 2'b00));

  p_lsb_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && cfg_ratio == 2'd0) |-> (left_o[1:0] == 2'b00 && right_o[1:0] == 2'b00));

  p_edge_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_edge |=> (bit_cnt == '0));

endmodule

bind pcm_serial_rx pcm_rx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .valid_o    (valid_o),
  .left_o     (left_o),
  .right_o    (right_o),
  .cfg_p18    (cfg_p18),
  .cfg_ratio  (cfg_ratio),
  .frame_edge (frame_edge_w),
  .bit_cnt    (bit_cnt_w)
);

// File: tb/pcm_serial_rx_tb.sv
module pcm_serial_rx_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_lj = 1'b1, cfg_p18 = 1'b0;
  logic [1:0]  cfg_ratio = 2'd0;
  logic        bit_clk_i = 1'b0, word_clk_i = 1'b0, ser_data_i = 1'b0;
  logic [17:0] left_o, right_o;
  logic        valid_o;

  int checks = 0;
  int fails  = 0;
  logic prev_bit = 1'b0;
  logic [17:0] exp_l_q[$];
  logic [17:0] exp_r_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  pcm_serial_rx u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_lj(cfg_lj), .cfg_p18(cfg_p18),
    .cfg_ratio(cfg_ratio), .bit_clk_i(bit_clk_i), .word_clk_i(word_clk_i),
    .ser_data_i(ser_data_i), .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int cap_of(input logic [1:0] r);
    return (r == 2'd0) ? 16 : (r == 2'd1) ? 24 : 32;
  endfunction

  // keep the top n bits of a left-aligned word
  function automatic logic [17:0] keep_top(input logic [17:0] w, input int n);
    logic [17:0] m = '0;
    for (int i = 0; i < n && i < 18; i++) m[17-i] = 1'b1;
    return w & m;
  endfunction

  // one bit-clock period; data and word clock change with the falling edge
  task automatic slot(input logic ws, input logic b);
    @(negedge clk);
    word_clk_i = ws;
    ser_data_i = cfg_lj ? b : prev_bit;
    prev_bit   = b;
    repeat (4) @(negedge clk);
    bit_clk_i = 1'b1;
    repeat (4) @(negedge clk);
    bit_clk_i = 1'b0;
  endtask

  task automatic send_half(input logic is_left, input logic [17:0] w, input int slots);
    int prec = cfg_p18 ? 18 : 16;
    logic lvl = cfg_lj ? is_left : ~is_left;
    for (int k = 0; k < slots; k++)
      slot(lvl, (k < prec) ? w[17-k] : 1'b1);   // junk after LSB is driven high
  endtask

  // driver: pushes expectation, then serializes one frame
  task automatic send_frame(input logic [17:0] l, input logic [17:0] r,
                            input int sl, input int sr, input bit push, input string tag);
    int prec = cfg_p18 ? 18 : 16;
    int c = cap_of(cfg_ratio);
    int nl = (prec < c) ? prec : c;
    int nr = nl;
    if (sl < nl) nl = sl;
    if (sr < nr) nr = sr;
    if (push) begin
      exp_l_q.push_back(keep_top(l, nl));
      exp_r_q.push_back(keep_top(r, nr));
      tag_q.push_back(tag);
    end
    send_half(1'b1, l, sl);
    send_half(1'b0, r, sr);
  endtask

  // monitor: pops and compares on each strobe
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (exp_l_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R10: unexpected pair actual %h/%h expected none", left_o, right_o);
      end else begin
        string t = tag_q.pop_front();
        check(t, left_o, exp_l_q.pop_front());
        check(t, right_o, exp_r_q.pop_front());
      end
    end
  end

  task automatic run_cfg(input logic lj, input logic p18, input logic [1:0] ratio);
    rst_n = 1'b0;
    cfg_lj = lj; cfg_p18 = p18; cfg_ratio = ratio;
    bit_clk_i = 1'b0;
    word_clk_i = lj ? 1'b0 : 1'b1;
    prev_bit = 1'b0;
    repeat (10) @(negedge clk);
    check("R1 reset left", left_o, 18'h0);
    check("R1 reset valid", {17'b0, valid_o}, 18'h0);
    rst_n = 1'b1;
    send_half(1'b0, 18'h0, 4);
  endtask

  task automatic flush(input string tag);
    int c = cap_of(cfg_ratio);
    send_frame(18'h3FFFF, 18'h3FFFF, c, c, 0, tag);
    repeat (20) @(negedge clk);
    checks++;
    if (exp_l_q.size() != 0) begin
      fails++;
      $display("FAIL %s: pending pairs actual %0d expected 0", tag, exp_l_q.size());
    end
  endtask

  initial begin
    // R2 R4 R7: left-justified, 16-bit, 48x
    run_cfg(1'b1, 1'b0, 2'd1);
    send_frame(18'h2A5C3, 18'h15A3C, 24, 24, 1, "R2 R4 R7 lj16x48");
    send_frame(18'h3FFFC, 18'h00004, 24, 24, 1, "R2 R4 lj16x48");
    send_frame(18'h20000, 18'h1FFFF, 24, 24, 1, "R2 R4 lj16x48");
    flush("R8 lj16x48");
    // R3 R5: I2S, 18-bit, 64x
    run_cfg(1'b0, 1'b1, 2'd2);
    send_frame(18'h2A5C3, 18'h15A3D, 32, 32, 1, "R3 R5 i2s18x64");
    send_frame(18'h00001, 18'h20000, 32, 32, 1, "R3 R5 i2s18x64");
    flush("R8 i2s18x64");
    // R6: I2S, 18-bit, 32x
    run_cfg(1'b0, 1'b1, 2'd0);
    send_frame(18'h3FFFF, 18'h2AAAB, 16, 16, 1, "R6 i2s18x32");
    send_frame(18'h12345, 18'h0F0F3, 16, 16, 1, "R6 i2s18x32");
    flush("R8 i2s18x32");
    // R6 R2: left-justified, 18-bit, 32x
    run_cfg(1'b1, 1'b1, 2'd0);
    send_frame(18'h3C3C3, 18'h1E1E1, 16, 16, 1, "R6 lj18x32");
    flush("R8 lj18x32");
    // R9: early edges, I2S 16-bit 64x
    run_cfg(1'b0, 1'b0, 2'd2);
    send_frame(18'h3FFFF, 18'h2AAAA, 10, 32, 1, "R9 i2s short left");
    send_frame(18'h1234C, 18'h3ABC4, 32, 32, 1, "R9 i2s resync");
    flush("R8 i2s16x64");
    // R9 R5: early right edge, left-justified 18-bit 48x
    run_cfg(1'b1, 1'b1, 2'd1);
    send_frame(18'h2D2D2, 18'h3FFFF, 24, 7, 1, "R9 lj short right");
    send_frame(18'h15555, 18'h2AAAA, 24, 24, 1, "R5 R9 lj resync");
    flush("R8 lj18x48");
    // R10: one left and right half after reset gives no pair
    run_cfg(1'b1, 1'b0, 2'd0);
    send_frame(18'h11111, 18'h22222, 16, 16, 0, "R10");
    repeat (20) @(negedge clk);
    check("R10 no early pair", left_o, 18'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule